// File: doc/BRIEF.md
# Serial Control-Register Slave with Auto-Incrementing Pointer

This block lets an external host program a small bank of 8-bit control registers over a standard two-wire I2C bus. Both bus lines are oversampled with the system clock. The slave finds START and STOP conditions and accepts only its own 7-bit device address. It drives SDA low through an open-drain enable and never drives it high. Every register value is presented on a wide parallel output, so the rest of the chip can use the settings directly.

In a write, the byte after the address loads an internal 8-bit pointer, and each later byte is stored at the pointer. A read has no pointer phase of its own. It returns bytes starting at whatever pointer the last write left behind. The pointer advances by one after every data byte, in both directions. One register slot acts as a software-reset trigger that restores the other registers to their power-on values. The system clock must run at least eight times faster than SCL.

Top module: `i2c_regbank`

## Requirements
- R1: After rst_n is released, register i (for i other than the soft-reset slot) presents 0x30 + 3*i on reg_q[8*i+7:8*i], the soft-reset slot reads 0, and sda_oe is 0.
- R2: The slave answers only to 7-bit device address 1000000. The first byte after START is the address in bits 7..1, followed by a direction bit in bit 0 (0 = write, 1 = read). On a match, the slave pulls SDA low for the ninth clock, and it raises sda_oe only while SCL is low.
- R3: Any other address gets no acknowledge. The slave then ignores all further bytes, writing nothing and acknowledging nothing, until the next START.
- R4: In a write, the second byte loads the pointer. Each later byte is stored in the register the pointer selects, and every byte is acknowledged. The stored value appears on reg_q once the byte ends.
- R5: The pointer increases by one after each data byte and wraps from 0xFF to 0x00. Writes to pointer values of NREG or above are dropped, and reads there return 0.
- R6: A read sends bytes MSB first, starting at the current pointer. The pointer advances once per byte that the master clocks in.
- R7: When the master does not acknowledge a read byte, the slave stops sending and keeps SDA released until the next START or STOP.
- R8: A repeated START restarts the byte sequence but keeps the pointer, so a write of a pointer followed by a repeated START and a read returns data from that pointer.
- R9: Writing 0x01 to slot NREG-1 returns every register to its R1 value. Writing any other value there changes nothing, and the slot always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_q | output | NREG*8 | All register values; register i occupies bits 8*i+7..8*i |

## Verification
Each bus line passes through two synchroniser stages and a previous-value flop before an edge is seen. As a result, sda_oe changes and register writes land three system clocks after the SCL edge that causes them. The bench drives each SCL phase for ten system clocks, so these results have settled by the next quarter-bit. It samples the acknowledge and read bits at the middle of SCL high, which is ten clocks after the rising edge. It checks reg_q and sda_oe only after a whole byte or a STOP has finished, well after the three-cycle latency. Expected register contents, pointer movement and read data come from a separate model in the bench that applies the write, wrap and soft-reset rules.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } proto_state_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_SUB,
    RX_DATA
  } rx_kind_t;

  // Power-on value of register idx.
  function automatic logic [7:0] reg_default(input int idx);
    return 8'(8'h30 + 3 * idx);
  endfunction

  // Pointer advance, wrapping at the top of the 8-bit range.
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return p + 8'd1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_regbank_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int SRST_IDX = NREG - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [7:0]      ptr,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] reg_flat
);
  logic [7:0] regs [NREG];
  logic sw_clr;

  assign sw_clr = wr_stb && (ptr == 8'(SRST_IDX)) && (wr_data == 8'h01);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == SRST_IDX) begin : g_trig
      assign regs[i] = 8'h00;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          regs[i] <= reg_default(i);
        else if (sw_clr)                     regs[i] <= reg_default(i);
        else if (wr_stb && ptr == 8'(i))     regs[i] <= wr_data;
      end
    end
    assign reg_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 8'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output logic       ptr_inc,
  output logic       byte_done
);
  proto_state_t state;
  rx_kind_t     kind;
  logic         is_read;
  logic [3:0]   cnt;
  logic [7:0]   sh;
  logic         mack_rise;

  assign byte_done = (state == ST_RX) && scl_fall && (cnt == 4'd8);
  assign wr_stb    = byte_done && (kind == RX_DATA) && !ev_start && !ev_stop;
  assign wr_data   = sh;
  assign mack_rise = (state == ST_MACK) && scl_rise && !ev_start && !ev_stop;
  assign ptr_inc   = wr_stb || mack_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= RX_ADDR;
      is_read <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state   <= ST_RX;
      kind    <= RX_ADDR;
      is_read <= 1'b0;
      cnt     <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          if (byte_done) begin
            case (kind)
              RX_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  is_read <= sh[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end
              RX_SUB: begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              default: begin
                ptr    <= ptr_next(ptr);
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (is_read) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == RX_ADDR) ? RX_SUB : RX_DATA;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sh     <= {sh[6:0], 1'b1};
              sda_oe <= ~sh[6];
            end
          end
        end
        ST_MACK: begin
          if (mack_rise) begin
            ptr   <= ptr_next(ptr);
            state <= sda_s ? ST_HOLD : ST_ACK;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int         NREG        = 16,
  parameter int         SRST_IDX    = NREG - 1,
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_q
);
  logic       sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic       wr_stb, ptr_inc, byte_done;
  logic [7:0] wr_data, ptr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_data(wr_data), .ptr(ptr), .ptr_inc(ptr_inc), .byte_done(byte_done)
  );

  i2c_reg_file #(.NREG(NREG), .SRST_IDX(SRST_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ptr(ptr),
    .wr_data(wr_data), .rd_data(rd_data), .reg_flat(reg_q)
  );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       wr_stb,
  input logic       ptr_inc,
  input logic [7:0] ptr
);
  p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && ev_stop));

  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> (ptr == 8'($past(ptr) + 8'd1)));

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  p_start_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  p_write_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sda_oe);
endmodule

bind i2c_regbank i2c_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .ev_start(ev_start), .ev_stop(ev_stop), .wr_stb(wr_stb),
  .ptr_inc(ptr_inc), .ptr(ptr)
);

// File: tb/sim_i2c_regbank.sv
`timescale 1ns/1ps
module sim_i2c_regbank;
  localparam int NREG = 16;
  localparam int SRST = NREG - 1;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] reg_q;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] expv [NREG];
  logic [7:0] mptr;

  always #5 clk = ~clk;

  i2c_regbank #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 3) + 48);
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] p);
    if (p >= 8'(NREG) || p == 8'(SRST)) return 8'h00;
    return expv[p[3:0]];
  endfunction

  task automatic model_wr(input logic [7:0] d);
    if (mptr == 8'(SRST)) begin
      if (d == 8'h01) for (int i = 0; i < NREG; i++) expv[i] = dflt(i);
    end else if (mptr < 8'(NREG)) begin
      expv[mptr[3:0]] = d;
    end
    mptr = mptr + 8'd1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, reg_q[i*8 +: 8], (i == SRST) ? 8'h00 : expv[i]);
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); sda_m = 1'b0; tq(); scl_m = 1'b0; tq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); sda_m = 1'b1; tq(); tq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tq(); scl_m = 1'b1; tq(); tq(); scl_m = 1'b0; tq();
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); v = sda_bus; tq(); scl_m = 1'b0; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = ~v;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      b[i] = v;
    end
    put_bit(~give_ack);
  endtask

  // write of a pointer then data bytes, acks checked
  task automatic wr_burst(input logic [7:0] sub, input int n, input logic [7:0] base, input logic [7:0] step);
    logic ack;
    bus_start();
    send_byte(8'h80, ack); chk("R2 addr ack", 8'(ack), 8'h01);
    send_byte(sub, ack);   chk("R4 sub ack", 8'(ack), 8'h01);
    mptr = sub;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(base + step * k);
      send_byte(d, ack);   chk("R4 data ack", 8'(ack), 8'h01);
      model_wr(d);
    end
    bus_stop();
  endtask

  task automatic rd_burst(input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'h81, ack); chk("R2 read addr ack", 8'(ack), 8'h01);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(req, b, model_rd(mptr));
      mptr = mptr + 8'd1;
    end
    tq(); tq();
    chk("R7 released after nack", 8'(sda_oe), 8'h00);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) expv[i] = dflt(i);
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    chk_regs("R1 reset value");
    chk("R1 sda_oe idle", 8'(sda_oe), 8'h00);

    // R4 R5: sweep every slot with a write burst from 0
    wr_burst(8'h00, NREG - 1, 8'hA1, 8'h0D);
    chk_regs("R4 burst write");

    // R6: read back all slots from pointer 0
    wr_burst(8'h00, 0, 8'h00, 8'h00);
    rd_burst(NREG, "R6 read data");

    // R7: next read continues after the nacked byte
    rd_burst(2, "R7 pointer after nack");

    // R3: wrong addresses, write and read direction
    for (int a = 0; a < 128; a += 9) begin
      if (a == 7'h40) continue;
      bus_start();
      send_byte({7'(a), a[0]}, ack); chk("R3 no ack wrong addr", 8'(ack), 8'h00);
      send_byte(8'h02, ack);         chk("R3 ignored byte", 8'(ack), 8'h00);
      send_byte(8'h5A, ack);         chk("R3 ignored byte", 8'(ack), 8'h00);
      bus_stop();
    end
    chk_regs("R3 no write after mismatch");

    // R5: wrap from 0xFF to 0x00, writes above NREG dropped
    wr_burst(8'hFE, 3, 8'h11, 8'h22);
    chk("R5 wrap to slot 0", reg_q[7:0], 8'h55);
    chk_regs("R5 out of range dropped");
    rd_burst(1, "R5 read after wrap");
    wr_burst(8'(NREG), 0, 8'h00, 8'h00);
    rd_burst(3, "R5 out of range reads 0");

    // R8: repeated start keeps pointer
    bus_start();
    send_byte(8'h80, ack); chk("R8 addr ack", 8'(ack), 8'h01);
    send_byte(8'h05, ack); chk("R8 sub ack", 8'(ack), 8'h01);
    mptr = 8'h05;
    bus_start();
    send_byte(8'h81, ack); chk("R8 read addr ack", 8'(ack), 8'h01);
    recv_byte(1'b1, b); chk("R8 first byte", b, model_rd(8'h05));
    recv_byte(1'b0, b); chk("R8 second byte", b, model_rd(8'h06));
    mptr = 8'h07;
    bus_stop();

    // R9: soft reset slot
    wr_burst(8'(SRST), 1, 8'h02, 8'h00);
    chk_regs("R9 non-trigger value ignored");
    wr_burst(8'(SRST), 1, 8'h01, 8'h00);
    chk_regs("R9 soft reset restores defaults");
    wr_burst(8'(SRST), 0, 8'h00, 8'h00);
    rd_burst(1, "R9 trigger slot reads 0");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(negedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule